// File: doc/BRIEF.md
# PWM Compare Stage with Deferred Update

This block is the compare stage of a pulse-width generator. It contains a 16-bit down counter that reloads from a programmable period value. It also holds a compare value in two copies: a pending copy that software writes and an active copy that the comparator uses. When the counter reaches the active compare value, the block raises a single-cycle match pulse. The waveform generator, the interrupt enable logic and the ADC trigger logic downstream all take this pulse as a source.

Software never changes the active compare value in the middle of a period. A new value waits in the pending copy until the counter reaches zero. A per-block mode bit decides whether that zero boundary is enough on its own (local mode). The alternative is that the boundary must also follow a chip-wide synchronous-update request, which the block latches until the next zero (global mode). This keeps several generators in lock-step. If software writes twice before an update happens, the first value is dropped.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After a synchronous active-low reset, `cnt_value`, the pending and active compare values and `reg_rdata` at every address are zero, and `match_pulse` is low.
- R2: While `cnt_run` is high, the counter steps down by one each clock. From zero it reloads the period value on the next clock. `zero_pulse` is high in exactly the cycles where `cnt_run` is high and `cnt_value` is zero. While `cnt_run` is low, the counter holds.
- R3: `match_pulse` is high in the cycle after the one in which `cnt_value` equals the active compare value.
- R4: There is at most one match pulse per counter period, including when the counter is stopped at the compare value. A new period starts at each zero event.
- R5: If the active compare value is greater than the period value, `match_pulse` stays low.
- R6: With mode bit 0 of the control word cleared (local mode), a pending compare value becomes active at the next zero event.
- R7: With mode bit 0 set (global mode), a pending value becomes active only at a zero event at which a synchronous-update request is latched. At any other zero event, the active value is unchanged.
- R8: A high `sync_req` is latched. The latch is consumed and cleared at every zero event. A request that arrives in the cycle of a zero event is kept for the following zero.
- R9: A compare write made before the pending value is applied replaces it. Only the most recent write ever becomes active.
- R10: Register port: address 0 is the period value in bits 15:0. Address 1 is the control word with the mode in bit 0. Address 2 is the compare value. A compare read returns the last written pending value in bits 15:0 and zero in bits 31:16. Written bits 31:16 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 period, 1 control, 2 compare) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| cnt_run | input | 1 | Counter enable |
| sync_req | input | 1 | Chip-wide synchronous-update request |
| cnt_value | output | 16 | Current counter value |
| zero_pulse | output | 1 | Counter zero event |
| match_pulse | output | 1 | Compare match pulse for generator, interrupt and ADC trigger |

## Verification
The timing of each result is fixed:
- The counter moves on the rising edge after `cnt_run` is seen.
- The match pulse shows one clock after the counter shows the active value.
- A new compare value is in use from the cycle after the zero event that applies it.
- Readback reflects a write from the edge that stores it.

The bench drives inputs and samples outputs on falling edges only. Each sampled pulse is paired with the counter value from the previous sample. After a zero event the bench skips two samples before it counts, so that no pulse from the old value falls into the window. Each counting window spans a whole number of periods, so the expected pulse count is exact.

// File: rtl/pwm_cmp_pkg.sv
// Package: shared widths and register addresses for the PWM compare stage.
// Assumes a 2-bit register address space with three used locations.
package pwm_cmp_pkg;
    localparam int CNT_W_DEF  = 16;
    localparam int DATA_W_DEF = 32;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_PERIOD = 2'd0,
        ADDR_CTRL   = 2'd1,
        ADDR_CMP    = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    // Control word bit positions
    localparam int CTRL_MODE_BIT = 0;
endpackage

// File: rtl/pwm_cmp_regs.sv
// Module: register port. Holds the period value and the mode bit, and
// strobes compare writes to the shadow stage. Readback is combinational.
// Assumes single-cycle writes; the compare pending value is kept elsewhere.
module pwm_cmp_regs
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  pend_value,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  period,
    output logic              sync_mode,
    output logic              cmp_wr,
    output logic [CNT_W-1:0]  cmp_wdata
);
    localparam int PAD_W = DATA_W - CNT_W;

    reg_addr_e sel;
    assign sel       = reg_addr_e'(addr);
    assign cmp_wr    = wr_en && (sel == ADDR_CMP);
    assign cmp_wdata = wdata[CNT_W-1:0];

    // Store period and mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period    <= '0;
            sync_mode <= 1'b0;
        end else if (wr_en) begin
            if (sel == ADDR_PERIOD) period    <= wdata[CNT_W-1:0];
            if (sel == ADDR_CTRL)   sync_mode <= wdata[CTRL_MODE_BIT];
        end
    end

    // Readback mux; upper bits always read as zero.
    always_comb begin
        unique case (sel)
            ADDR_PERIOD: rdata = {{PAD_W{1'b0}}, period};
            ADDR_CTRL:   rdata = {{(DATA_W-1){1'b0}}, sync_mode};
            ADDR_CMP:    rdata = {{PAD_W{1'b0}}, pend_value};
            default:     rdata = '0;
        endcase
    end

    // R10
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == ADDR_CMP && (|wdata[DATA_W-1:CNT_W]))
            |=> (pend_value == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/pwm_cmp_counter.sv
// Module: down counter. Counts from the period value to zero and reloads.
// The zero event is one clock wide and only occurs while running.
module pwm_cmp_counter
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_evt
);
    assign zero_evt = run && (cnt == '0);

    // Count down, reload at zero, hold when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (zero_evt) cnt <= period;
        else if (run)      cnt <= cnt - 1'b1;
    end

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> (cnt == $past(period)));
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
endmodule

// File: rtl/pwm_cmp_shadow.sv
// Module: pending/active compare pair and update control. A write lands in
// pending; at a zero event it moves to active in local mode, or in global
// mode only when a latched synchronous request is present.
module pwm_cmp_shadow
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             sync_mode,
    input  logic             sync_req,
    input  logic             zero_evt,
    output logic [CNT_W-1:0] pending,
    output logic [CNT_W-1:0] active
);
    logic pend_valid;
    logic sync_flag;
    logic apply;

    assign apply = zero_evt && pend_valid && (!sync_mode || sync_flag);

    // Pending value: the latest write always wins.
    always_ff @(posedge clk) begin
        if (!rst_n)  pending <= '0;
        else if (wr) pending <= wdata;
    end

    // Pending-valid flag: set by a write, cleared when applied.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_valid <= 1'b0;
        else if (wr)    pend_valid <= 1'b1;
        else if (apply) pend_valid <= 1'b0;
    end

    // Synchronous-request latch, consumed at each zero event.
    always_ff @(posedge clk) begin
        if (!rst_n)        sync_flag <= 1'b0;
        else if (zero_evt) sync_flag <= sync_req;
        else if (sync_req) sync_flag <= 1'b1;
    end

    // Active compare update at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     active <= '0;
        else if (apply) active <= pending;
    end

    // R6
    local_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && pend_valid && !sync_mode) |=> (active == $past(pending)));
    // R7
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_evt |=> $stable(active));
    // R7
    global_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && sync_mode && !sync_flag) |=> $stable(active));
    // R8
    sync_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> (sync_flag == $past(sync_req)));
    // R9
    latest_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pending == $past(wdata)));
endmodule

// File: rtl/pwm_cmp_match.sv
// Module: comparator. Registers a one-cycle pulse when the counter equals
// the active value, at most once per period, never when the value is past
// the period value.
module pwm_cmp_match
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] active,
    input  logic [CNT_W-1:0] period,
    input  logic             zero_evt,
    output logic             match
);
    logic fired;
    logic hit;

    assign hit = (cnt == active) && (active <= period) && !fired;

    // Once-per-period guard, re-armed at each zero event.
    always_ff @(posedge clk) begin
        if (!rst_n)        fired <= 1'b0;
        else if (zero_evt) fired <= 1'b0;
        else if (hit)      fired <= 1'b1;
    end

    // Registered match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) match <= 1'b0;
        else        match <= hit;
    end

    // R3
    match_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ($past(cnt) == $past(active)));
    // R5
    above_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active > period) |=> !match);
    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !zero_evt && $stable(cnt)) |=> !match);
endmodule

// File: rtl/pwm_cmp_unit.sv
// Module: top of the PWM compare stage. Connects the register port, the
// down counter, the pending/active compare pair and the comparator.
// Assumes one clock domain and a synchronous active-low reset.
module pwm_cmp_unit
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cnt_run,
    input  logic              sync_req,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              zero_pulse,
    output logic              match_pulse
);
    logic [CNT_W-1:0] period;
    logic             sync_mode;
    logic             cmp_wr;
    logic [CNT_W-1:0] cmp_wdata;
    logic [CNT_W-1:0] pend_value;
    logic [CNT_W-1:0] act_value;

    pwm_cmp_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .pend_value(pend_value), .rdata(reg_rdata),
        .period(period), .sync_mode(sync_mode), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata)
    );

    pwm_cmp_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run(cnt_run), .period(period),
        .cnt(cnt_value), .zero_evt(zero_pulse)
    );

    pwm_cmp_shadow #(.CNT_W(CNT_W)) shadow_i (
        .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(cmp_wdata),
        .sync_mode(sync_mode), .sync_req(sync_req), .zero_evt(zero_pulse),
        .pending(pend_value), .active(act_value)
    );

    pwm_cmp_match #(.CNT_W(CNT_W)) match_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_value), .active(act_value),
        .period(period), .zero_evt(zero_pulse), .match(match_pulse)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!match_pulse && cnt_value == '0));
endmodule

// File: tb/pwm_cmp_unit_tb.sv
// Directed bench for pwm_cmp_unit: one task per scenario, each checking itself.
module pwm_cmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cnt_run = 1'b0;
    logic        sync_req = 1'b0;
    logic [15:0] cnt_value;
    logic        zero_pulse;
    logic        match_pulse;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam int PERIOD_VAL = 9;
    localparam int SPAN = PERIOD_VAL + 1;

    always #2 clk = ~clk;   // 250 MHz

    pwm_cmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_run(cnt_run),
        .sync_req(sync_req), .cnt_value(cnt_value), .zero_pulse(zero_pulse),
        .match_pulse(match_pulse)
    );

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_zero();
        do @(negedge clk); while (!zero_pulse);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Count pulses over n samples; each pulse is paired with the prior counter value.
    task automatic observe(input int n, input int exp_val, output int pulses, output int wrong);
        int prev;
        prev = cnt_value; pulses = 0; wrong = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (match_pulse) begin
                pulses++;
                if (prev != exp_val) wrong++;
            end
            prev = cnt_value;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cnt_value == 0, "R1 counter", cnt_value, 0);
        check(match_pulse == 1'b0, "R1 match", match_pulse, 0);
        for (int a = 0; a < 4; a++) begin
            reg_read(a[1:0], d);
            check(d == 0, "R1 readback", d, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_counter();
        int z;
        int v;
        reg_write(2'd0, PERIOD_VAL);
        reg_write(2'd1, 32'd0);
        cnt_run = 1'b1;
        do @(negedge clk); while (!zero_pulse);
        check(cnt_value == 0, "R2 zero flag at zero", cnt_value, 0);
        @(negedge clk);
        check(cnt_value == PERIOD_VAL, "R2 reload", cnt_value, PERIOD_VAL);
        @(negedge clk);
        check(cnt_value == PERIOD_VAL - 1, "R2 step", cnt_value, PERIOD_VAL - 1);
        z = 0;
        for (int i = 0; i < 3 * SPAN; i++) begin
            @(negedge clk);
            if (zero_pulse) z++;
        end
        check(z == 3, "R2 zero events per span", z, 3);
        cnt_run = 1'b0;
        @(negedge clk);
        v = cnt_value;
        repeat (5) @(negedge clk);
        check(cnt_value == v && !zero_pulse, "R2 hold", cnt_value, v);
        cnt_run = 1'b1;
    endtask

    task automatic t_local(input int cmp, input int exp_pulses, input string tag);
        int p;
        int w;
        reg_write(2'd2, cmp);
        wait_zero();
        observe(3 * SPAN, cmp, p, w);
        check(p == exp_pulses, tag, p, exp_pulses);
        check(w == 0, tag, w, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        reg_write(2'd2, 32'hABCD_0007);
        reg_read(2'd2, d);
        check(d == 32'h0000_0007, "R10 compare readback", d, 7);
        reg_read(2'd0, d);
        check(d == PERIOD_VAL, "R10 period readback", d, PERIOD_VAL);
        reg_read(2'd1, d);
        check(d == 0, "R10 control readback", d, 0);
    endtask

    task automatic t_held();
        int p;
        int w;
        reg_write(2'd2, 5);
        wait_zero();
        do @(negedge clk); while (cnt_value != 5);
        cnt_run = 1'b0;
        observe(12, 5, p, w);
        check(p == 1 && w == 0, "R4 one pulse while held", p, 1);
        cnt_run = 1'b1;
    endtask

    task automatic t_global();
        logic [31:0] d;
        int p;
        int w;
        reg_write(2'd1, 32'd1);
        reg_read(2'd1, d);
        check(d == 1, "R10 mode readback", d, 1);
        reg_write(2'd2, 3);
        wait_zero();
        wait_zero();
        observe(2 * SPAN, 5, p, w);
        check(p == 2 && w == 0, "R7 old value kept without request", p, 2);
        @(negedge clk); sync_req = 1'b1;
        @(negedge clk); sync_req = 1'b0;
        wait_zero();
        observe(3 * SPAN, 3, p, w);
        check(p == 3 && w == 0, "R7 applied after request", p, 3);
    endtask

    task automatic t_overwrite();
        logic [31:0] d;
        int p;
        int w;
        reg_write(2'd2, 7);
        reg_write(2'd2, 2);
        reg_read(2'd2, d);
        check(d == 2, "R9 latest pending", d, 2);
        @(negedge clk); sync_req = 1'b1;
        @(negedge clk); sync_req = 1'b0;
        wait_zero();
        observe(3 * SPAN, 2, p, w);
        check(p == 3 && w == 0, "R9 earlier write discarded", w, 0);
    endtask

    task automatic t_consumed();
        int p;
        int w;
        reg_write(2'd2, 6);
        wait_zero();
        wait_zero();
        observe(3 * SPAN, 2, p, w);
        check(p == 3 && w == 0, "R8 request consumed at zero", w, 0);
    endtask

    initial begin
        int p;
        int w;
        t_reset();
        t_counter();
        t_local(4, 3, "R6 local update and R3 match");
        t_local(PERIOD_VAL, 3, "R3 compare equal to period");
        t_local(0, 3, "R3 compare zero");
        t_local(12, 0, "R5 compare above period");
        t_readback();
        wait_zero();
        observe(3 * SPAN, 7, p, w);
        check(p == 3 && w == 0, "R10 upper bits ignored", p, 3);
        t_held();
        t_global();
        t_overwrite();
        t_consumed();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule